// File: doc/BRIEF.md
# Shared-Bus Host Sample Port

This block sits between a host processor and a converter data path. Both sides exchange 16-bit two's-complement sample words over a bus that several ports share. The host writes a transmit word with a write-strobe pulse and reads the current receive word by pulling chip select and output enable low. Each port on the shared bus has its own chip select. A lone port may have chip select tied low.

The host strobes are asynchronous to the block clock. They pass through an input register stage. Two small state machines then interpret them.

- The write machine has the states `WR_IDLE` and `WR_LOW`.
  - `WR_IDLE` goes to `WR_LOW` when write enable and chip select are both low.
  - `WR_LOW` goes back to `WR_IDLE` on the capture transition: write enable rises while chip select is still low, and the bus word is stored.
  - `WR_LOW` also goes back to `WR_IDLE` on the abort transition: chip select rises while write enable is still low, and nothing is stored.
- The read machine has the states `RD_HIZ` and `RD_DRIVE`.
  - `RD_HIZ` goes to `RD_DRIVE` once both chip select and output enable are low.
  - `RD_DRIVE` goes back to `RD_HIZ` as soon as either of them is high.

Both data buffers change only on the sample strobe, which pulses once per interrupt period.

- The transmit buffer loads the word the host last captured. In loopback mode it loads the receive buffer instead.
- The receive buffer loads the incoming sample plus a signed offset, saturated to the 16-bit range. In read-back mode it loads the host's captured word instead.

Top module: `hpdp_top`

## Requirements
- R1: After reset the transmit word and the receive buffer are 0, and the bus is not driven (`bus_oe` = 0).
- R2: A word is captured when write enable rises while chip select is low. The word is the bus value held across that rise. It reaches `tx_word` at the first sample strobe after the capture. A capture that falls in the same cycle as a strobe goes out at the following strobe.
- R3: If chip select rises while write enable is still low, the write is discarded, and the previously captured word is kept.
- R4: The bus is driven with the receive buffer only while both chip select and output enable are low. It returns to high impedance when either one goes high.
- R5: `tx_word` and the receive buffer change only in the cycle after `sample_tick` is high.
- R6: The receive buffer loads `rx_sample` plus the signed offset {`ofs_hi`, `ofs_lo`}, where `ofs_hi` supplies bits 15:8 and `ofs_lo` supplies bits 7:0.
- R7: The offset sum saturates at 0x7FFF (+32767) and 0x8000 (−32768) instead of wrapping.
- R8: With `mode_dloop` = 1, a strobe loads `tx_word` with the receive buffer value held before that strobe, and the host word is not used.
- R9: With `mode_rdbk` = 1, a strobe loads the receive buffer with the last captured host word instead of the adjusted sample.
- R10: With both modes set, the receive buffer follows R9 and `tx_word` follows R8, both in the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_i | input | 16 | Bus value seen at the pins |
| bus_o | output | 16 | Word driven onto the bus |
| bus_oe | output | 1 | Bus drive enable; 0 means high impedance |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; capture on its rise |
| oe_n | input | 1 | Output enable, active low |
| sample_tick | input | 1 | One-cycle pulse per interrupt period |
| rx_sample | input | 16 | Receive sample from the converter path |
| ofs_lo | input | 8 | Offset bits 7:0 |
| ofs_hi | input | 8 | Offset bits 15:8 |
| mode_dloop | input | 1 | Digital loopback enable |
| mode_rdbk | input | 1 | Transmit read-back test enable |
| tx_word | output | 16 | Transmit word toward the converter |

## Verification
Two collisions can occur in the same cycle.

The first is a host write capture coinciding with a sample strobe. The bench raises write enable and `sample_tick` on the same clock edge. It then expects `tx_word` to keep the older word at that strobe and to show the new word only at the next one.

The second is a strobe landing in loopback or read-back mode. There the transmit buffer takes the receive buffer's old value while the receive buffer is replaced in the same edge. The bench judges this by reading the bus and `tx_word` afterwards against values it derives from the earlier writes and samples.

// File: rtl/hpdp_pkg.sv
package hpdp_pkg;
    localparam int DATA_W = 16;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_LOW  = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_HIZ   = 1'b0,
        RD_DRIVE = 1'b1
    } rd_state_t;
endpackage

// File: rtl/hpdp_in_reg.sv
// Registers the asynchronous host strobes and bus value once.
module hpdp_in_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         we_n,
    input  logic         oe_n,
    input  logic [W-1:0] bus_i,
    output logic         cs_q,
    output logic         we_q,
    output logic         oe_q,
    output logic [W-1:0] bus_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            we_q  <= 1'b1;
            oe_q  <= 1'b1;
            bus_q <= '0;
        end else begin
            cs_q  <= cs_n;
            we_q  <= we_n;
            oe_q  <= oe_n;
            bus_q <= bus_i;
        end
    end
endmodule

// File: rtl/hpdp_wr_fsm.sv
// Write strobe interpreter: capture on the rise of write enable while selected.
module hpdp_wr_fsm
    import hpdp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_q,
    input  logic         we_q,
    input  logic [W-1:0] bus_q,
    output logic [W-1:0] tx_hold
);
    wr_state_t state, state_nx;
    logic      capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            WR_IDLE: begin
                if (!cs_q && !we_q) state_nx = WR_LOW;
            end
            WR_LOW: begin
                if (cs_q) begin
                    state_nx = WR_IDLE;          // abort: select dropped first
                end else if (we_q) begin
                    state_nx = WR_IDLE;          // capture: strobe rose while selected
                    capture  = 1'b1;
                end
            end
            default: state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_hold <= '0;
        else if (capture) tx_hold <= bus_q;
    end
endmodule

// File: rtl/hpdp_rd_fsm.sv
// Read gate: drive only while both select and output enable are low.
module hpdp_rd_fsm
    import hpdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_q,
    input  logic oe_q,
    output logic drive
);
    rd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_HIZ;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_HIZ:   if (!cs_q && !oe_q) state_nx = RD_DRIVE;
            RD_DRIVE: if (cs_q || oe_q)   state_nx = RD_HIZ;
            default:  state_nx = RD_HIZ;
        endcase
    end

    always_comb begin
        drive = (state == RD_DRIVE);
    end
endmodule

// File: rtl/hpdp_sat_add.sv
// Signed add with clamp to the W-bit two's-complement range.
module hpdp_sat_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    always_comb begin
        sum = {a[W-1], a} + {b[W-1], b};
        if (sum[W] != sum[W-1]) y = sum[W] ? NEG_MIN : POS_MAX;
        else                    y = sum[W-1:0];
    end
endmodule

// File: rtl/hpdp_top.sv
module hpdp_top #(
    parameter int DATA_W = hpdp_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              sample_tick,
    input  logic [DATA_W-1:0] rx_sample,
    input  logic [DATA_W/2-1:0] ofs_lo,
    input  logic [DATA_W/2-1:0] ofs_hi,
    input  logic              mode_dloop,
    input  logic              mode_rdbk,
    output logic [DATA_W-1:0] tx_word
);
    localparam int HALF_W = DATA_W / 2;

    logic              cs_q, we_q, oe_q;
    logic [DATA_W-1:0] bus_q;
    logic [DATA_W-1:0] tx_hold;
    logic [DATA_W-1:0] rx_buf;
    logic [DATA_W-1:0] rx_adj;
    logic [DATA_W-1:0] offset;

    assign offset = {ofs_hi[HALF_W-1:0], ofs_lo[HALF_W-1:0]};

    hpdp_in_reg #(.W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .bus_i(bus_i),
        .cs_q(cs_q), .we_q(we_q), .oe_q(oe_q), .bus_q(bus_q)
    );

    hpdp_wr_fsm #(.W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .cs_q(cs_q), .we_q(we_q), .bus_q(bus_q),
        .tx_hold(tx_hold)
    );

    hpdp_rd_fsm u_rd (
        .clk(clk), .rst_n(rst_n),
        .cs_q(cs_q), .oe_q(oe_q),
        .drive(bus_oe)
    );

    hpdp_sat_add #(.W(DATA_W)) u_add (
        .a(rx_sample), .b(offset), .y(rx_adj)
    );

    // Receive buffer: read-back overrides the adjusted sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rx_buf <= '0;
        else if (sample_tick) rx_buf <= mode_rdbk ? tx_hold : rx_adj;
    end

    // Transmit buffer: loopback takes the receive buffer's present word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tx_word <= '0;
        else if (sample_tick) tx_word <= mode_dloop ? rx_buf : tx_hold;
    end

    assign bus_o = rx_buf;
endmodule

// File: rtl/hpdp_chk.sv
module hpdp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_q,
    input logic         oe_q,
    input logic         bus_oe,
    input logic         sample_tick,
    input logic         mode_dloop,
    input logic         mode_rdbk,
    input logic [W-1:0] tx_word,
    input logic [W-1:0] tx_hold,
    input logic [W-1:0] rx_buf
);
    AST_DRIVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!cs_q && !oe_q)); // R4
    AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q || oe_q) |=> !bus_oe); // R4
    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(tx_word)); // R5
    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(rx_buf)); // R5
    AST_LOOPBACK_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && mode_dloop) |=> (tx_word == $past(rx_buf))); // R8
    AST_READBACK_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && mode_rdbk) |=> (rx_buf == $past(tx_hold))); // R9
    AST_NORMAL_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && !mode_dloop) |=> (tx_word == $past(tx_hold))); // R2
endmodule

bind hpdp_top hpdp_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_q(cs_q), .oe_q(oe_q), .bus_oe(bus_oe),
    .sample_tick(sample_tick), .mode_dloop(mode_dloop), .mode_rdbk(mode_rdbk),
    .tx_word(tx_word), .tx_hold(tx_hold), .rx_buf(rx_buf)
);

// File: tb/hpdp_tb.sv
`timescale 1ns/1ps
module hpdp_top_tb_top;
    localparam int W = 16;
    localparam int NV = 8;
    // {rx_sample, offset, expected receive word}
    localparam logic [47:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'h0000},
        {16'h1234, 16'h0010, 16'h1244},
        {16'h7FF0, 16'h0020, 16'h7FFF},
        {16'h8010, 16'hFFE0, 16'h8000},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h8000, 16'h7FFF, 16'hFFFF},
        {16'h7FFF, 16'h8000, 16'hFFFF},
        {16'h4000, 16'h4000, 16'h7FFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] bus_i = '0;
    logic [W-1:0] bus_o;
    logic bus_oe;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic sample_tick = 1'b0;
    logic [W-1:0] rx_sample = '0;
    logic [7:0] ofs_lo = '0, ofs_hi = '0;
    logic mode_dloop = 1'b0, mode_rdbk = 1'b0;
    logic [W-1:0] tx_word;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hpdp_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .sample_tick(sample_tick),
        .rx_sample(rx_sample), .ofs_lo(ofs_lo), .ofs_hi(ofs_hi),
        .mode_dloop(mode_dloop), .mode_rdbk(mode_rdbk), .tx_word(tx_word)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
    endtask

    task automatic host_write(input logic [W-1:0] d);
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; bus_i = d;
        wait_n(2);
        we_n = 1'b1;
        wait_n(3);
        cs_n = 1'b1; bus_i = '0;
        wait_n(2);
    endtask

    // Reads the bus; also checks release after output enable rises.
    task automatic host_read(input string tag, output logic [W-1:0] v);
        @(negedge clk); cs_n = 1'b0; oe_n = 1'b0;
        wait_n(3);
        chk({tag, " R4 drive"}, {15'b0, bus_oe}, 16'h0001);
        v = bus_o;
        oe_n = 1'b1;
        wait_n(3);
        chk({tag, " R4 release"}, {15'b0, bus_oe}, 16'h0000);
        cs_n = 1'b1;
        wait_n(2);
    endtask

    initial begin
        logic [W-1:0] rd;
        wait_n(4);
        // R1: reset state
        chk("R1 tx_word", tx_word, 16'h0000);
        chk("R1 bus_oe", {15'b0, bus_oe}, 16'h0000);
        rst_n = 1'b1;
        wait_n(2);
        host_read("R1 rx_buf", rd);
        chk("R1 rx_buf", rd, 16'h0000);

        // R6/R7 table
        for (int i = 0; i < NV; i++) begin
            rx_sample = VEC[i][47:32];
            {ofs_hi, ofs_lo} = VEC[i][31:16];
            tick();
            host_read("R6 R7 table", rd);
            chk($sformatf("R6 R7 vec%0d", i), rd, VEC[i][15:0]);
        end

        // R4: only one of the two selects low
        @(negedge clk); oe_n = 1'b0; cs_n = 1'b1;
        wait_n(4);
        chk("R4 oe only", {15'b0, bus_oe}, 16'h0000);
        oe_n = 1'b1; cs_n = 1'b0;
        wait_n(4);
        chk("R4 cs only", {15'b0, bus_oe}, 16'h0000);
        cs_n = 1'b1;
        wait_n(2);

        // R2/R5: write then strobe
        host_write(16'hA5C3);
        chk("R5 before tick", tx_word, 16'h0000);
        tick();
        chk("R2 after tick", tx_word, 16'hA5C3);

        // R3: select rises first -> discarded
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; bus_i = 16'h1111;
        wait_n(2);
        cs_n = 1'b1;
        wait_n(3);
        we_n = 1'b1;
        wait_n(2);
        tick();
        chk("R3 discarded", tx_word, 16'hA5C3);

        // R2: capture in the same cycle as a strobe
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; bus_i = 16'h2468;
        wait_n(2);
        we_n = 1'b1; sample_tick = 1'b1;  // we_q rises at the same edge the strobe is taken
        @(negedge clk); sample_tick = 1'b0;
        chk("R2 same-cycle old word", tx_word, 16'hA5C3);
        wait_n(2); cs_n = 1'b1; wait_n(2);
        tick();
        chk("R2 same-cycle next tick", tx_word, 16'h2468);

        // R8: loopback
        rx_sample = 16'h0BEE; {ofs_hi, ofs_lo} = 16'h0000;
        tick();                              // rx_buf = 0BEE
        mode_dloop = 1'b1;
        rx_sample = 16'h0C00;
        tick();                              // tx_word = 0BEE, rx_buf = 0C00
        chk("R8 loopback", tx_word, 16'h0BEE);
        mode_dloop = 1'b0;

        // R9: read-back
        host_write(16'h5A5A);
        mode_rdbk = 1'b1;
        tick();
        host_read("R9", rd);
        chk("R9 readback", rd, 16'h5A5A);
        mode_rdbk = 1'b0;

        // R10: both modes
        rx_sample = 16'h0321;
        tick();                              // rx_buf = 0321, tx_word = 5A5A
        host_write(16'h7E57);
        mode_dloop = 1'b1; mode_rdbk = 1'b1;
        tick();
        chk("R10 tx from old rx", tx_word, 16'h0321);
        host_read("R10", rd);
        chk("R10 rx from host word", rd, 16'h7E57);
        mode_dloop = 1'b0; mode_rdbk = 1'b0;

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule